// File: doc/BRIEF.md
# Display Mode Line Sanitizer

This block accepts a requested video mode line and returns a corrected one that a raster timing generator can hold. A mode line carries four horizontal values in pixels (display end, sync start, sync end, total) and four vertical values in lines. The block applies a fixed chain of alignment and clamp rules. Several bounds are measured from values that an earlier rule has already corrected, so the order of the rules is part of the behaviour.

Each rule group is one register stage of a five-stage pipeline. A valid/ready handshake sits on each side. When the output is held back, the whole pipeline stalls. A generation-select input, sampled with each mode line, picks between a wide and a narrow set of maximum display sizes. Each result carries an eight-bit "adjusted" mask. A bit is set when any clamp rule moved that field.

Top module: `mode_line_sanitizer`

## Requirements
- R1: All four horizontal outputs are the corrected value with its low three bits cleared, so each is a multiple of 8. Clearing these bits alone sets no adjusted flag.
- R2: Horizontal display end is held within [640, 2048] when `wide_gen`=1 and within [640, 1920] when `wide_gen`=0. Vertical display end is held within [480, 1536] when `wide_gen`=1 and within [480, 1440] when `wide_gen`=0.
- R3: Before any range clamp, the vertical inputs are confined to an 11-bit register range. Display end is capped at 0x7FD, sync start at 0x7FE, sync end at 0x7FF and total at 0x801.
- R4: Horizontal total is first raised to at least display end + 80. It is then lowered to at most display end + 0x3F8.
- R5: Horizontal sync end is capped at total − 8, and sync start is raised to at least display end + 8. After that, sync end is capped at sync start + 0xF8, which is 31 character cells of 8 pixels.
- R6: Vertical total is first raised to at least display end + 3. It is then lowered to at most display end + 0xFF.
- R7: Vertical sync end is capped at total − 1, and sync start is raised to at least display end + 1. After that, sync end is capped at sync start + 0x0F.
- R8: Each bound is computed from the values already corrected by the earlier rules. For example, the total window is measured from the clamped display end, not from the requested one.
- R9: `out_adj` bit positions are: [0] h display end, [1] h sync start, [2] h sync end, [3] h total, [4] v display end, [5] v sync start, [6] v sync end, [7] v total. A bit is 1 when at least one clamp rule changed that field on its way through the pipeline.
- R10: `in_ready` = `out_ready` OR NOT `out_valid`. A mode line accepted at a rising edge while the output is not stalled appears, with `out_valid`=1, after the fourth following rising edge. Reset leaves `out_valid`=0.
- R11: While `out_valid`=1 and `out_ready`=0, the output stays valid with unchanged data and flags, and no input is accepted. Items already inside the pipeline keep their order and are delivered one per cycle once `out_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Requested mode line is present |
| in_ready | output | 1 | Block accepts the mode line this cycle |
| wide_gen | input | 1 | 1 selects the larger display size limits |
| in_hde | input | W | Requested horizontal display end (pixels) |
| in_hss | input | W | Requested horizontal sync start |
| in_hse | input | W | Requested horizontal sync end |
| in_ht | input | W | Requested horizontal total |
| in_vde | input | W | Requested vertical display end (lines) |
| in_vss | input | W | Requested vertical sync start |
| in_vse | input | W | Requested vertical sync end |
| in_vt | input | W | Requested vertical total |
| out_valid | output | 1 | Corrected mode line is present |
| out_ready | input | 1 | Consumer takes the corrected mode line |
| out_hde | output | W | Corrected horizontal display end |
| out_hss | output | W | Corrected horizontal sync start |
| out_hse | output | W | Corrected horizontal sync end |
| out_ht | output | W | Corrected horizontal total |
| out_vde | output | W | Corrected vertical display end |
| out_vss | output | W | Corrected vertical sync start |
| out_vse | output | W | Corrected vertical sync end |
| out_vt | output | W | Corrected vertical total |
| out_adj | output | 8 | Per-field adjusted mask |

## Verification
With the consumer ready, every result must appear exactly four rising edges after the edge that accepted its input. The bench counts edges from the accepting edge and samples on each following falling edge, so a result that comes one cycle early or late fails the latency check before any field is compared. In the stall scenario, the first item reaches the output and the bench then holds the output for six cycles, checking it on each falling edge. After `out_ready` rises, the second item must arrive on the very next edge.

// File: rtl/mls_pkg.sv
package mls_pkg;
   localparam int NF    = 8;
   localparam int F_HDE = 0;
   localparam int F_HSS = 1;
   localparam int F_HSE = 2;
   localparam int F_HT  = 3;
   localparam int F_VDE = 4;
   localparam int F_VSS = 5;
   localparam int F_VSE = 6;
   localparam int F_VT  = 7;
   localparam int NSTAGE = 5;
endpackage

// File: rtl/mls_stage.sv
module mls_stage
   import mls_pkg::*;
#(
   parameter int W              = 16,
   parameter int STAGE          = 0,
   parameter int H_GRAN_BITS    = 3,
   parameter int V_FIELD_BITS   = 11,
   parameter int HDE_MIN        = 640,
   parameter int HDE_MAX_WIDE   = 2048,
   parameter int HDE_MAX_NARROW = 1920,
   parameter int VDE_MIN        = 480,
   parameter int VDE_MAX_WIDE   = 1536,
   parameter int VDE_MAX_NARROW = 1440,
   parameter int HT_MIN_BLANK   = 80,
   parameter int HT_MAX_BLANK   = 1016,
   parameter int VT_MIN_BLANK   = 3,
   parameter int VT_MAX_BLANK   = 255,
   parameter int HSE_BITS       = 5,
   parameter int VSE_BITS       = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   v_i,
   input  logic [NF-1:0][W-1:0]   d_i,
   input  logic [NF-1:0]          f_i,
   input  logic                   gen_i,
   output logic                   v_o,
   output logic [NF-1:0][W-1:0]   d_o,
   output logic [NF-1:0]          f_o,
   output logic                   gen_o
);
   localparam int V_FIELD_MAX = (1 << V_FIELD_BITS) - 1;
   localparam logic [W:0] C_VDE_CAP = (W+1)'(V_FIELD_MAX - 2);
   localparam logic [W:0] C_VSS_CAP = (W+1)'(V_FIELD_MAX - 1);
   localparam logic [W:0] C_VSE_CAP = (W+1)'(V_FIELD_MAX);
   localparam logic [W:0] C_VT_CAP  = (W+1)'(V_FIELD_MAX + 2);
   localparam logic [W:0] C_HDE_MIN = (W+1)'(HDE_MIN);
   localparam logic [W:0] C_HMAX_W  = (W+1)'(HDE_MAX_WIDE);
   localparam logic [W:0] C_HMAX_N  = (W+1)'(HDE_MAX_NARROW);
   localparam logic [W:0] C_VDE_MIN = (W+1)'(VDE_MIN);
   localparam logic [W:0] C_VMAX_W  = (W+1)'(VDE_MAX_WIDE);
   localparam logic [W:0] C_VMAX_N  = (W+1)'(VDE_MAX_NARROW);
   localparam logic [W:0] C_HT_MIN  = (W+1)'(HT_MIN_BLANK);
   localparam logic [W:0] C_HT_MAX  = (W+1)'(HT_MAX_BLANK);
   localparam logic [W:0] C_VT_MIN  = (W+1)'(VT_MIN_BLANK);
   localparam logic [W:0] C_VT_MAX  = (W+1)'(VT_MAX_BLANK);
   localparam logic [W:0] C_HGAP    = (W+1)'(1 << H_GRAN_BITS);
   localparam logic [W:0] C_VGAP    = (W+1)'(1);
   localparam logic [W:0] C_HSLEN   = (W+1)'(((1 << HSE_BITS) - 1) << H_GRAN_BITS);
   localparam logic [W:0] C_VSLEN   = (W+1)'((1 << VSE_BITS) - 1);

   logic [NF-1:0][W:0] x;
   logic [NF-1:0][W:0] y;
   logic [NF-1:0]      nf;

   function automatic logic [W:0] lower_to(input logic [W:0] v, input logic [W:0] lim,
                                           inout logic fl);
      if (v > lim) begin
         fl = 1'b1;
         return lim;
      end
      return v;
   endfunction

   function automatic logic [W:0] raise_to(input logic [W:0] v, input logic [W:0] lim,
                                           inout logic fl);
      if (v < lim) begin
         fl = 1'b1;
         return lim;
      end
      return v;
   endfunction

   always_comb begin
      for (int i = 0; i < NF; i++) x[i] = {1'b0, d_i[i]};
   end

   generate
      if (STAGE == 0) begin : g_align
         always_comb begin
            y  = x;
            nf = f_i;
            for (int i = F_HDE; i <= F_HT; i++) y[i][H_GRAN_BITS-1:0] = '0;
            y[F_VDE] = lower_to(y[F_VDE], C_VDE_CAP, nf[F_VDE]);
            y[F_VSS] = lower_to(y[F_VSS], C_VSS_CAP, nf[F_VSS]);
            y[F_VSE] = lower_to(y[F_VSE], C_VSE_CAP, nf[F_VSE]);
            y[F_VT]  = lower_to(y[F_VT],  C_VT_CAP,  nf[F_VT]);
         end
      end else if (STAGE == 1) begin : g_display
         always_comb begin
            y  = x;
            nf = f_i;
            y[F_HDE] = raise_to(y[F_HDE], C_HDE_MIN, nf[F_HDE]);
            y[F_HDE] = lower_to(y[F_HDE], gen_i ? C_HMAX_W : C_HMAX_N, nf[F_HDE]);
            y[F_VDE] = raise_to(y[F_VDE], C_VDE_MIN, nf[F_VDE]);
            y[F_VDE] = lower_to(y[F_VDE], gen_i ? C_VMAX_W : C_VMAX_N, nf[F_VDE]);
         end
      end else if (STAGE == 2) begin : g_total
         always_comb begin
            y  = x;
            nf = f_i;
            y[F_HT] = raise_to(y[F_HT], y[F_HDE] + C_HT_MIN, nf[F_HT]);
            y[F_HT] = lower_to(y[F_HT], y[F_HDE] + C_HT_MAX, nf[F_HT]);
            y[F_VT] = raise_to(y[F_VT], y[F_VDE] + C_VT_MIN, nf[F_VT]);
            y[F_VT] = lower_to(y[F_VT], y[F_VDE] + C_VT_MAX, nf[F_VT]);
         end
      end else if (STAGE == 3) begin : g_place
         always_comb begin
            y  = x;
            nf = f_i;
            y[F_HSE] = lower_to(y[F_HSE], y[F_HT]  - C_HGAP, nf[F_HSE]);
            y[F_HSS] = raise_to(y[F_HSS], y[F_HDE] + C_HGAP, nf[F_HSS]);
            y[F_VSE] = lower_to(y[F_VSE], y[F_VT]  - C_VGAP, nf[F_VSE]);
            y[F_VSS] = raise_to(y[F_VSS], y[F_VDE] + C_VGAP, nf[F_VSS]);
         end
      end else if (STAGE == 4) begin : g_length
         always_comb begin
            y  = x;
            nf = f_i;
            y[F_HSE] = lower_to(y[F_HSE], y[F_HSS] + C_HSLEN, nf[F_HSE]);
            y[F_VSE] = lower_to(y[F_VSE], y[F_VSS] + C_VSLEN, nf[F_VSE]);
         end
      end else begin : g_bad
         $error("mls_stage: STAGE out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         d_o   <= '0;
         f_o   <= '0;
         gen_o <= 1'b0;
      end else if (en) begin
         v_o   <= v_i;
         for (int i = 0; i < NF; i++) d_o[i] <= y[i][W-1:0];
         f_o   <= nf;
         gen_o <= gen_i;
      end
   end
endmodule

// File: rtl/mode_line_sanitizer.sv
module mode_line_sanitizer
   import mls_pkg::*;
#(
   parameter int W              = 16,
   parameter int H_GRAN_BITS    = 3,
   parameter int V_FIELD_BITS   = 11,
   parameter int HDE_MIN        = 640,
   parameter int HDE_MAX_WIDE   = 2048,
   parameter int HDE_MAX_NARROW = 1920,
   parameter int VDE_MIN        = 480,
   parameter int VDE_MAX_WIDE   = 1536,
   parameter int VDE_MAX_NARROW = 1440,
   parameter int HT_MIN_BLANK   = 80,
   parameter int HT_MAX_BLANK   = 1016,
   parameter int VT_MIN_BLANK   = 3,
   parameter int VT_MAX_BLANK   = 255,
   parameter int HSE_BITS       = 5,
   parameter int VSE_BITS       = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic         wide_gen,
   input  logic [W-1:0] in_hde,
   input  logic [W-1:0] in_hss,
   input  logic [W-1:0] in_hse,
   input  logic [W-1:0] in_ht,
   input  logic [W-1:0] in_vde,
   input  logic [W-1:0] in_vss,
   input  logic [W-1:0] in_vse,
   input  logic [W-1:0] in_vt,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_hde,
   output logic [W-1:0] out_hss,
   output logic [W-1:0] out_hse,
   output logic [W-1:0] out_ht,
   output logic [W-1:0] out_vde,
   output logic [W-1:0] out_vss,
   output logic [W-1:0] out_vse,
   output logic [W-1:0] out_vt,
   output logic [7:0]   out_adj
);
   localparam int HSLEN = ((1 << HSE_BITS) - 1) << H_GRAN_BITS;
   localparam int VSLEN = (1 << VSE_BITS) - 1;
   localparam int HGAP  = 1 << H_GRAN_BITS;

   generate
      if (W < V_FIELD_BITS + 2) begin : g_chk_w
         $error("mode_line_sanitizer: W too narrow for vertical field range");
      end
      if (HDE_MAX_WIDE + HT_MAX_BLANK >= (1 << W)) begin : g_chk_h
         $error("mode_line_sanitizer: W too narrow for horizontal totals");
      end
      if (HDE_MIN > HDE_MAX_NARROW || VDE_MIN > VDE_MAX_NARROW) begin : g_chk_r
         $error("mode_line_sanitizer: empty display range");
      end
   endgenerate

   logic                          en;
   logic [NSTAGE:0]               vv;
   logic [NSTAGE:0][NF-1:0][W-1:0] dd;
   logic [NSTAGE:0][NF-1:0]       ff;
   logic [NSTAGE:0]               gg;

   assign en       = out_ready | ~out_valid;
   assign in_ready = en;

   assign vv[0] = in_valid;
   assign gg[0] = wide_gen;
   assign ff[0] = '0;
   assign dd[0][F_HDE] = in_hde;
   assign dd[0][F_HSS] = in_hss;
   assign dd[0][F_HSE] = in_hse;
   assign dd[0][F_HT]  = in_ht;
   assign dd[0][F_VDE] = in_vde;
   assign dd[0][F_VSS] = in_vss;
   assign dd[0][F_VSE] = in_vse;
   assign dd[0][F_VT]  = in_vt;

   for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
      mls_stage #(
         .W(W), .STAGE(k), .H_GRAN_BITS(H_GRAN_BITS), .V_FIELD_BITS(V_FIELD_BITS),
         .HDE_MIN(HDE_MIN), .HDE_MAX_WIDE(HDE_MAX_WIDE), .HDE_MAX_NARROW(HDE_MAX_NARROW),
         .VDE_MIN(VDE_MIN), .VDE_MAX_WIDE(VDE_MAX_WIDE), .VDE_MAX_NARROW(VDE_MAX_NARROW),
         .HT_MIN_BLANK(HT_MIN_BLANK), .HT_MAX_BLANK(HT_MAX_BLANK),
         .VT_MIN_BLANK(VT_MIN_BLANK), .VT_MAX_BLANK(VT_MAX_BLANK),
         .HSE_BITS(HSE_BITS), .VSE_BITS(VSE_BITS)
      ) u_stage (
         .clk(clk), .rst_n(rst_n), .en(en),
         .v_i(vv[k]), .d_i(dd[k]), .f_i(ff[k]), .gen_i(gg[k]),
         .v_o(vv[k+1]), .d_o(dd[k+1]), .f_o(ff[k+1]), .gen_o(gg[k+1])
      );
   end

   assign out_valid = vv[NSTAGE];
   assign out_adj   = ff[NSTAGE];
   assign out_hde   = dd[NSTAGE][F_HDE];
   assign out_hss   = dd[NSTAGE][F_HSS];
   assign out_hse   = dd[NSTAGE][F_HSE];
   assign out_ht    = dd[NSTAGE][F_HT];
   assign out_vde   = dd[NSTAGE][F_VDE];
   assign out_vss   = dd[NSTAGE][F_VSS];
   assign out_vse   = dd[NSTAGE][F_VSE];
   assign out_vt    = dd[NSTAGE][F_VT];

   AST_H_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_hde | out_hss | out_hse | out_ht) & W'(HGAP - 1)) == '0); // R1
   AST_DISPLAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_hde) >= HDE_MIN && int'(out_hde) <= HDE_MAX_WIDE &&
                     int'(out_vde) >= VDE_MIN && int'(out_vde) <= VDE_MAX_WIDE)); // R2
   AST_HTOTAL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_ht) - int'(out_hde) >= HT_MIN_BLANK &&
                     int'(out_ht) - int'(out_hde) <= HT_MAX_BLANK)); // R4
   AST_HSYNC_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_hse) <= int'(out_ht) - HGAP &&
                     int'(out_hss) >= int'(out_hde) + HGAP &&
                     int'(out_hse) <= int'(out_hss) + HSLEN)); // R5
   AST_VTOTAL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_vt) - int'(out_vde) >= VT_MIN_BLANK &&
                     int'(out_vt) - int'(out_vde) <= VT_MAX_BLANK)); // R6
   AST_VSYNC_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_vse) <= int'(out_vt) - 1 &&
                     int'(out_vss) >= int'(out_vde) + 1 &&
                     int'(out_vse) <= int'(out_vss) + VSLEN)); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(dd[NSTAGE]) &&
                                     $stable(out_adj))); // R11
   AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R11
endmodule

// File: tb/mode_line_sanitizer_bench.sv
module mode_line_sanitizer_bench;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic wide_gen = 1'b0;
   logic [W-1:0] in_hde = '0, in_hss = '0, in_hse = '0, in_ht = '0;
   logic [W-1:0] in_vde = '0, in_vss = '0, in_vse = '0, in_vt = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [W-1:0] out_hde, out_hss, out_hse, out_ht, out_vde, out_vss, out_vse, out_vt;
   logic [7:0] out_adj;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mode_line_sanitizer u_mode_line_sanitizer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .wide_gen(wide_gen),
      .in_hde(in_hde), .in_hss(in_hss), .in_hse(in_hse), .in_ht(in_ht),
      .in_vde(in_vde), .in_vss(in_vss), .in_vse(in_vse), .in_vt(in_vt),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_hde(out_hde), .out_hss(out_hss), .out_hse(out_hse), .out_ht(out_ht),
      .out_vde(out_vde), .out_vss(out_vss), .out_vse(out_vse), .out_vt(out_vt),
      .out_adj(out_adj)
   );

   typedef int ml_t [8];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic void lower(inout int v, input int lim, inout bit fl);
      if (v > lim) begin v = lim; fl = 1; end
   endfunction
   function automatic void raise(inout int v, input int lim, inout bit fl);
      if (v < lim) begin v = lim; fl = 1; end
   endfunction

   // expected result built from the requirement text
   function automatic void expect_ml(input ml_t a, input bit g, output ml_t e, output bit [7:0] f);
      f = '0;
      e = a;
      for (int i = 0; i < 4; i++) e[i] = e[i] & ~7;                  // R1
      lower(e[4], 'h7FD, f[4]); lower(e[5], 'h7FE, f[5]);            // R3
      lower(e[6], 'h7FF, f[6]); lower(e[7], 'h801, f[7]);
      raise(e[0], 640, f[0]); lower(e[0], g ? 2048 : 1920, f[0]);    // R2
      raise(e[4], 480, f[4]); lower(e[4], g ? 1536 : 1440, f[4]);
      raise(e[3], e[0] + 80, f[3]); lower(e[3], e[0] + 'h3F8, f[3]); // R4
      raise(e[7], e[4] + 3, f[7]); lower(e[7], e[4] + 'hFF, f[7]);   // R6
      lower(e[2], e[3] - 8, f[2]); raise(e[1], e[0] + 8, f[1]);      // R5
      lower(e[6], e[7] - 1, f[6]); raise(e[5], e[4] + 1, f[5]);      // R7
      lower(e[2], e[1] + 'hF8, f[2]); lower(e[6], e[5] + 'h0F, f[6]);
   endfunction

   task automatic drive(input ml_t a, input bit g);
      in_hde = W'(a[0]); in_hss = W'(a[1]); in_hse = W'(a[2]); in_ht = W'(a[3]);
      in_vde = W'(a[4]); in_vss = W'(a[5]); in_vse = W'(a[6]); in_vt = W'(a[7]);
      wide_gen = g;
      in_valid = 1'b1;
   endtask

   task automatic compare_out(input string tag, input ml_t e, input bit [7:0] f);
      chk(tag, "h display end", int'(out_hde), e[0]);
      chk(tag, "h sync start",  int'(out_hss), e[1]);
      chk(tag, "h sync end",    int'(out_hse), e[2]);
      chk(tag, "h total",       int'(out_ht),  e[3]);
      chk(tag, "v display end", int'(out_vde), e[4]);
      chk(tag, "v sync start",  int'(out_vss), e[5]);
      chk(tag, "v sync end",    int'(out_vse), e[6]);
      chk(tag, "v total",       int'(out_vt),  e[7]);
      chk("R9", "adjusted mask", int'(out_adj), int'(f));
   endtask

   // one mode line through an idle pipeline, consumer always ready
   task automatic run_one(input string tag, input ml_t a, input bit g);
      ml_t e;
      bit [7:0] f;
      int n;
      expect_ml(a, g, e, f);
      @(negedge clk);
      out_ready = 1'b1;
      drive(a, g);
      chk("R10", "in_ready before accept", int'(in_ready), 1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      n = 0;
      for (int i = 1; i <= 10; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (out_valid) begin n = i; break; end
      end
      chk("R10", "edges to out_valid", n, 4);
      if (n != 0) compare_out(tag, e, f);
   endtask

   task automatic t_reset;
      chk("R10", "out_valid after reset", int'(out_valid), 0);
      chk("R10", "in_ready after reset", int'(in_ready), 1);
   endtask

   task automatic t_nominal;
      run_one("R9", '{800, 840, 968, 1056, 600, 601, 605, 628}, 1'b0);
   endtask

   task automatic t_align;
      run_one("R1", '{803, 845, 975, 1061, 600, 601, 605, 628}, 1'b1);
   endtask

   task automatic t_display_range;
      run_one("R2", '{2048, 2100, 2200, 2400, 1536, 1540, 1545, 1600}, 1'b0);
      run_one("R2", '{2048, 2100, 2200, 2400, 1536, 1540, 1545, 1600}, 1'b1);
      run_one("R2", '{320, 336, 400, 400, 200, 210, 212, 220}, 1'b1);
   endtask

   task automatic t_vconfine;
      run_one("R3", '{1024, 1048, 1184, 1344, 'h900, 'h9F0, 'hFFFF, 'hFFFF}, 1'b1);
   endtask

   task automatic t_order;
      run_one("R8", '{3000, 3008, 3100, 3100, 1500, 1490, 1495, 1800}, 1'b0);
   endtask

   task automatic t_htotal;
      run_one("R4", '{1024, 1030, 1040, 1050, 768, 771, 777, 806}, 1'b1);
      run_one("R4", '{1024, 1100, 2000, 4000, 768, 771, 777, 806}, 1'b1);
   endtask

   task automatic t_hsync;
      run_one("R5", '{1280, 1000, 1800, 1688, 1024, 1025, 1028, 1066}, 1'b1);
      run_one("R5", '{1280, 1296, 1700, 1800, 1024, 1025, 1028, 1066}, 1'b1);
   endtask

   task automatic t_vtotal;
      run_one("R6", '{1024, 1048, 1184, 1344, 768, 769, 770, 700}, 1'b1);
      run_one("R6", '{1024, 1048, 1184, 1344, 768, 769, 770, 1200}, 1'b1);
   endtask

   task automatic t_vsync;
      run_one("R7", '{1024, 1048, 1184, 1344, 768, 700, 900, 806}, 1'b1);
      run_one("R7", '{1024, 1048, 1184, 1344, 768, 780, 830, 900}, 1'b1);
   endtask

   task automatic t_stall;
      ml_t a, b, c, ea, eb;
      bit [7:0] fa, fb;
      a = '{1024, 1048, 1184, 1344, 768, 771, 777, 806};
      b = '{700, 712, 900, 800, 500, 490, 560, 520};
      c = '{1280, 1328, 1440, 1688, 1024, 1025, 1028, 1066};
      expect_ml(a, 1'b1, ea, fa);
      expect_ml(b, 1'b0, eb, fb);
      @(negedge clk);
      out_ready = 1'b0;
      drive(a, 1'b1);
      @(posedge clk);
      @(negedge clk);
      drive(b, 1'b0);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11", "first item reached output", int'(out_valid), 1);
      drive(c, 1'b1);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R11", "out_valid held", int'(out_valid), 1);
         chk("R11", "in_ready low while stalled", int'(in_ready), 0);
         compare_out("R11", ea, fa);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      chk("R11", "second item next cycle", int'(out_valid), 1);
      compare_out("R11", eb, fb);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R11", "no item from ignored input", int'(out_valid), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_nominal();
      t_align();
      t_display_range();
      t_vconfine();
      t_order();
      t_htotal();
      t_hsync();
      t_vtotal();
      t_vsync();
      t_stall();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule